// File: doc/BRIEF.md
# Dual-Mode Processor Counter/Timer

This block is a per-processor counter/timer behind a 32-bit register port. A mode input picks one of two behaviours for the same set of registers. In counter mode the block is a periodic limit timer. A tick-driven count is compared against a programmable limit. On a match the block sets a reached flag and raises a level interrupt. A zero limit makes the count free-run across its full range with no match. In user mode the same storage becomes a wide counter that software can preset, start and stop, and it never interrupts.

The count's least significant bit sits at register bit 9, so a tick adds 0x200 and bits 8..0 of a count always read zero. The counter-mode count is `LIM_W` tick bits wide (default 22, so the wrap value is 0x7FFFFE00). The user-mode count is `USER_TICK_W` tick bits wide (default 45, a 54-bit register value). Register offsets are byte addresses, and only aligned word accesses are decoded. Reads return data in the same cycle the request is presented. Side effects of a read take place at the clock edge that ends the request.

A small controller holds the mode state. It has three states: `ST_COUNT` (counter mode, always counting), `ST_USER_HALT` (user mode, stopped) and `ST_USER_RUN` (user mode, counting). Its transitions are:
- **enter-user**: from `ST_COUNT` to `ST_USER_RUN` or `ST_USER_HALT` when the mode input rises, chosen by the stored run bit.
- **start**: from `ST_USER_HALT` to `ST_USER_RUN` on a run-bit write of 1.
- **stop**: from `ST_USER_RUN` to `ST_USER_HALT` on a run-bit write of 0.
- **leave-user**: from either user state back to `ST_COUNT` when the mode input falls.

Top module: `proc_cnt_timer`

## Requirements
- R1: After reset the block is in counter mode with limit 0, count 0 and reached flag 0. Offsets 0x0, 0x4 and 0xC read 0, `irq` is low, and the count advances free on each tick.
- R2: The count advances by one tick exactly in cycles with `tick_en` high. In counter mode offset 0x4 returns the count in bits 30:9 (low `LIM_W` tick bits from bit 9), the reached flag in bit 31, and zeros in bits 8:0.
- R3: With limit 0 the counter-mode count wraps from its maximum (0x7FFFFE00 at default width, 0x7E00 with `LIM_W`=6) to 0, and neither the reached flag nor `irq` is ever set.
- R4: In counter mode a write to 0x0 stores the limit from bits 9..9+`LIM_W`-1 and drops all other bits. It also restarts the count at 0 and deasserts `irq`.
- R5: In counter mode, when a tick makes the count equal a non-zero limit L, bit 31 (reached) and `irq` are set. The next tick takes the count to 0x200, so after n ticks from a restart the count is n for n < L and ((n-1) mod L)+1 otherwise. `irq` stays high until cleared.
- R6: In counter mode a read of 0x0 returns the reached flag in bit 31 with the limit in bits 30:9, and then clears both the reached flag and `irq`. A read of 0x4 clears neither.
- R7: In counter mode a write to 0x8 replaces the limit without disturbing the count. A limit below the current count is next reached only after the count wraps.
- R8: Reads of offsets other than 0x0, 0x4, 0x8 and 0xC, or with address bits 1:0 non-zero, return 0, and writes to them change nothing. Offset 0x8 reads 0. In counter mode, writes to 0x4 and 0xC are ignored.
- R9: In user mode, 0x4 holds the low 23 tick bits in bits 31:9. Offset 0x0 holds the upper `USER_TICK_W`-23 tick bits from bit 0, with the reached flag in bit 31. Writing either word presets only that part of the count.
- R10: In user mode, writing 0xC bit 0 as 1 starts the count and as 0 stops it. A stopped count holds across ticks. Bit 0 of 0xC reads back the run bit in both modes.
- R11: In user mode the count wraps from all ones to zero and sets the reached flag. Reads do not clear the flag, and `irq` is never asserted while in user mode.
- R12: On entry to user mode, `irq` and the reached flag are cleared and the count is kept. The count then runs at once if the run bit is 1 and stays stopped otherwise.
- R13: On return to counter mode, the limit, count and reached flag are cleared, and the count runs free from 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count tick |
| user_mode | input | 1 | 1 selects user mode, 0 counter mode |
| req_valid | input | 1 | Register access this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid while a read is presented |
| irq | output | 1 | Level interrupt, counter mode only |

## Verification
The bench builds the block with `LIM_W`=6 and the default `USER_TICK_W`=45. The narrow counter-mode width makes a full wrap 64 ticks, so every non-zero limit from 1 to 63 can be swept. Each sweep point checks the match instant, the restart arithmetic and the read-to-clear behaviour, and the free-run wrap is also within reach. The full user width is kept because presets put the count next to the 23-bit word boundary and the 45-bit top, so the carry between words and the user wrap take only a few ticks.

// File: rtl/pct_pkg.sv
package pct_pkg;

    localparam int CNT_LSB   = 9;
    localparam int LO_TICK_W = 32 - CNT_LSB;

    localparam logic [1:0] WIDX_HI  = 2'd0;
    localparam logic [1:0] WIDX_LO  = 2'd1;
    localparam logic [1:0] WIDX_NR  = 2'd2;
    localparam logic [1:0] WIDX_RUN = 2'd3;

    typedef enum logic [1:0] {
        ST_COUNT     = 2'd0,
        ST_USER_HALT = 2'd1,
        ST_USER_RUN  = 2'd2
    } pct_state_e;

endpackage

// File: rtl/pct_ctrl.sv
module pct_ctrl
    import pct_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic user_mode,
    input  logic wr_run,
    input  logic run_wbit,
    output logic is_user,
    output logic advancing,
    output logic ent_user,
    output logic ent_count,
    output logic run_q
);

    pct_state_e state_q, state_d;
    logic       run_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            run_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_d   = state_q;
        run_d     = run_q;
        ent_user  = 1'b0;
        ent_count = 1'b0;
        unique case (state_q)
            ST_COUNT: begin
                if (user_mode) begin
                    ent_user = 1'b1;
                    state_d  = run_q ? ST_USER_RUN : ST_USER_HALT;
                end
            end
            ST_USER_HALT: begin
                if (!user_mode) begin
                    ent_count = 1'b1;
                    state_d   = ST_COUNT;
                end else if (wr_run) begin
                    run_d   = run_wbit;
                    state_d = run_wbit ? ST_USER_RUN : ST_USER_HALT;
                end
            end
            ST_USER_RUN: begin
                if (!user_mode) begin
                    ent_count = 1'b1;
                    state_d   = ST_COUNT;
                end else if (wr_run) begin
                    run_d   = run_wbit;
                    state_d = run_wbit ? ST_USER_RUN : ST_USER_HALT;
                end
            end
            default: state_d = ST_COUNT;
        endcase
    end

    assign is_user   = (state_q != ST_COUNT);
    assign advancing = (state_q != ST_USER_HALT);

    a_r10_run_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER_RUN) |-> run_q);

    a_r10_halt_state: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_USER_HALT) |-> !run_q);

endmodule

// File: rtl/pct_count.sv
module pct_count
    import pct_pkg::*;
#(
    parameter int LIM_W       = 22,
    parameter int USER_TICK_W = 45
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   tick_en,
    input  logic                   is_user,
    input  logic                   advancing,
    input  logic                   ent_user,
    input  logic                   ent_count,
    input  logic                   wr_hi,
    input  logic                   wr_lo,
    input  logic                   wr_nr,
    input  logic                   rd_hi,
    input  logic [31:0]            wdata,
    output logic [USER_TICK_W-1:0] cnt_q,
    output logic [LIM_W-1:0]       lim_q,
    output logic                   reached_q,
    output logic                   irq_q
);

    localparam int HI_W = USER_TICK_W - LO_TICK_W;

    logic [USER_TICK_W-1:0] cnt_d;
    logic [LIM_W-1:0]       lim_d;
    logic                   reached_d;
    logic                   irq_d;
    logic [LIM_W-1:0]       cnt_lo;
    logic [LIM_W-1:0]       step_lo;
    logic [LIM_W-1:0]       wlim;
    logic                   at_limit;

    assign cnt_lo   = cnt_q[LIM_W-1:0];
    assign wlim     = wdata[CNT_LSB +: LIM_W];
    assign at_limit = (lim_q != '0) && (cnt_lo == lim_q);
    assign step_lo  = at_limit ? {{(LIM_W-1){1'b0}}, 1'b1} : cnt_lo + 1'b1;

    always_comb begin
        cnt_d     = cnt_q;
        lim_d     = lim_q;
        reached_d = reached_q;
        irq_d     = irq_q;
        if (tick_en && advancing) begin
            if (is_user) begin
                cnt_d = cnt_q + 1'b1;
                if (&cnt_q) reached_d = 1'b1;
            end else begin
                cnt_d = USER_TICK_W'(step_lo);
                if ((lim_q != '0) && (step_lo == lim_q)) begin
                    reached_d = 1'b1;
                    irq_d     = 1'b1;
                end
            end
        end
        if (!is_user) begin
            if (wr_hi) begin
                lim_d = wlim;
                cnt_d = '0;
                irq_d = 1'b0;
            end else if (wr_nr) begin
                lim_d = wlim;
            end
            if (rd_hi) begin
                reached_d = 1'b0;
                irq_d     = 1'b0;
            end
        end else begin
            if (wr_hi) cnt_d[USER_TICK_W-1:LO_TICK_W] = wdata[HI_W-1:0];
            if (wr_lo) cnt_d[LO_TICK_W-1:0] = wdata[31:CNT_LSB];
        end
        if (ent_user) begin
            irq_d     = 1'b0;
            reached_d = 1'b0;
        end
        if (ent_count) begin
            cnt_d     = '0;
            lim_d     = '0;
            reached_d = 1'b0;
            irq_d     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            lim_q     <= '0;
            reached_q <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            cnt_q     <= cnt_d;
            lim_q     <= lim_d;
            reached_q <= reached_d;
            irq_q     <= irq_d;
        end
    end

    a_r11_user_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        is_user |-> !irq_q);

    a_r5_irq_with_reached: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> reached_q);

    a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (is_user && !advancing && !wr_hi && !wr_lo && !ent_count) |=> $stable(cnt_q));

    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_user && rd_hi) |=> (!irq_q && !reached_q));

    a_r3_free_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!is_user && lim_q == '0 && !irq_q) |=> !irq_q);

endmodule

// File: rtl/pct_regs.sv
module pct_regs
    import pct_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int LIM_W       = 22,
    parameter int USER_TICK_W = 45
) (
    input  logic                   is_user,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [USER_TICK_W-1:0] cnt_q,
    input  logic [LIM_W-1:0]       lim_q,
    input  logic                   reached_q,
    input  logic                   run_q,
    output logic [31:0]            rd_data,
    output logic                   wr_hi,
    output logic                   wr_lo,
    output logic                   wr_nr,
    output logic                   wr_run,
    output logic                   rd_hi
);

    localparam int HI_W = USER_TICK_W - LO_TICK_W;

    logic       in_map;
    logic [1:0] widx;
    logic       do_wr;
    logic       do_rd;

    assign in_map = (req_addr[ADDR_W-1:4] == '0) && (req_addr[1:0] == 2'b00);
    assign widx   = req_addr[3:2];
    assign do_wr  = req_valid && req_write && in_map;
    assign do_rd  = req_valid && !req_write && in_map;

    assign wr_hi  = do_wr && (widx == WIDX_HI);
    assign wr_lo  = do_wr && (widx == WIDX_LO) && is_user;
    assign wr_nr  = do_wr && (widx == WIDX_NR) && !is_user;
    assign wr_run = do_wr && (widx == WIDX_RUN) && is_user;
    assign rd_hi  = do_rd && (widx == WIDX_HI);

    always_comb begin
        rd_data = '0;
        if (do_rd) begin
            unique case (widx)
                WIDX_HI: begin
                    if (is_user) rd_data[HI_W-1:0] = cnt_q[USER_TICK_W-1:LO_TICK_W];
                    else         rd_data[CNT_LSB +: LIM_W] = lim_q;
                    rd_data[31] = reached_q;
                end
                WIDX_LO: begin
                    if (is_user) begin
                        rd_data[31:CNT_LSB] = cnt_q[LO_TICK_W-1:0];
                    end else begin
                        rd_data[CNT_LSB +: LIM_W] = cnt_q[LIM_W-1:0];
                        rd_data[31] = reached_q;
                    end
                end
                WIDX_RUN: rd_data[0] = run_q;
                default:  rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/proc_cnt_timer.sv
module proc_cnt_timer #(
    parameter int ADDR_W      = 5,
    parameter int LIM_W       = 22,
    parameter int USER_TICK_W = 45
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              user_mode,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rd_data,
    output logic              irq
);

    logic                   is_user, advancing, ent_user, ent_count, run_q;
    logic                   wr_hi, wr_lo, wr_nr, wr_run, rd_hi;
    logic [USER_TICK_W-1:0] cnt_q;
    logic [LIM_W-1:0]       lim_q;
    logic                   reached_q;

    pct_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .user_mode (user_mode),
        .wr_run    (wr_run),
        .run_wbit  (req_wdata[0]),
        .is_user   (is_user),
        .advancing (advancing),
        .ent_user  (ent_user),
        .ent_count (ent_count),
        .run_q     (run_q)
    );

    pct_count #(.LIM_W(LIM_W), .USER_TICK_W(USER_TICK_W)) u_count (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .is_user   (is_user),
        .advancing (advancing),
        .ent_user  (ent_user),
        .ent_count (ent_count),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_nr     (wr_nr),
        .rd_hi     (rd_hi),
        .wdata     (req_wdata),
        .cnt_q     (cnt_q),
        .lim_q     (lim_q),
        .reached_q (reached_q),
        .irq_q     (irq)
    );

    pct_regs #(.ADDR_W(ADDR_W), .LIM_W(LIM_W), .USER_TICK_W(USER_TICK_W)) u_regs (
        .is_user   (is_user),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .cnt_q     (cnt_q),
        .lim_q     (lim_q),
        .reached_q (reached_q),
        .run_q     (run_q),
        .rd_data   (rd_data),
        .wr_hi     (wr_hi),
        .wr_lo     (wr_lo),
        .wr_nr     (wr_nr),
        .wr_run    (wr_run),
        .rd_hi     (rd_hi)
    );

endmodule

// File: tb/proc_cnt_timer_bench.sv
module proc_cnt_timer_bench;

    localparam int AW = 5;
    localparam int LW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic          user_mode = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rd_data;
    logic          irq;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    proc_cnt_timer #(.ADDR_W(AW), .LIM_W(LW), .USER_TICK_W(45)) u_proc_cnt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .user_mode (user_mode),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic set_mode(input logic m);
        @(negedge clk);
        user_mode = m;
        @(negedge clk);
    endtask

    function automatic int period_cnt(input int lim, input int n);
        if (n < lim) return n;
        return ((n - 1) % lim) + 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] held;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'h00, d); chk("R1 limit", d, 32'h0);
        rd(5'h04, d); chk("R1 count", d, 32'h0);
        rd(5'h0C, d); chk("R1 run", d, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h0);

        // R2 ticks advance; idle cycles hold
        ticks(5);
        rd(5'h04, d); chk("R2 five ticks", d, 32'h0000_0A00);
        repeat (4) @(negedge clk);
        rd(5'h04, d); chk("R2 hold without tick", d, 32'h0000_0A00);

        // R4/R5/R6 sweep over every non-zero limit
        for (int lim = 1; lim < 64; lim++) begin
            wr(5'h00, (32'(lim) << 9) | 32'hFFFF_81FF);
            rd(5'h00, d); chk("R4 limit masked", d, 32'(lim) << 9);
            chk("R4 irq low after write", {31'h0, irq}, 32'h0);
            if (lim > 1) begin
                ticks(lim - 1);
                rd(5'h04, d); chk("R5 before match", d, 32'(lim - 1) << 9);
                chk("R5 irq before match", {31'h0, irq}, 32'h0);
            end
            ticks(1);
            chk("R5 irq at match", {31'h0, irq}, 32'h1);
            rd(5'h04, d); chk("R6 count read keeps flag", d, 32'h8000_0000 | (32'(lim) << 9));
            ticks(3);
            rd(5'h04, d);
            chk("R5 periodic restart", d, 32'h8000_0000 | (32'(period_cnt(lim, lim + 3)) << 9));
            chk("R5 irq level held", {31'h0, irq}, 32'h1);
            rd(5'h00, d); chk("R6 limit read", d, 32'h8000_0000 | (32'(lim) << 9));
            chk("R6 irq cleared", {31'h0, irq}, 32'h0);
            rd(5'h04, d); chk("R6 flag cleared", d, 32'(period_cnt(lim, lim + 3)) << 9);
        end

        // R8 ignored accesses
        wr(5'h00, 32'd10 << 9);
        ticks(4);
        wr(5'h04, 32'h1234_5600);
        rd(5'h04, d); chk("R8 count write ignored", d, 32'd4 << 9);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R8 run write ignored", d, 32'h0);
        wr(5'h10, 32'hFFFF_FFFF);
        wr(5'h1C, 32'hFFFF_FFFF);
        wr(5'h01, 32'h0000_0200);
        rd(5'h00, d); chk("R8 limit untouched", d, 32'd10 << 9);
        rd(5'h04, d); chk("R8 count untouched", d, 32'd4 << 9);
        for (int a = 16; a < 32; a += 4) begin
            rd(AW'(a), d); chk("R8 unmapped read", d, 32'h0);
        end
        rd(5'h05, d); chk("R8 misaligned read", d, 32'h0);
        rd(5'h08, d); chk("R8 offset 8 reads zero", d, 32'h0);

        // R7 limit update without restart
        wr(5'h08, 32'd20 << 9);
        rd(5'h04, d); chk("R7 count kept", d, 32'd4 << 9);
        rd(5'h00, d); chk("R7 new limit", d, 32'd20 << 9);
        ticks(15);
        chk("R7 irq before new limit", {31'h0, irq}, 32'h0);
        ticks(1);
        chk("R7 irq at new limit", {31'h0, irq}, 32'h1);
        rd(5'h00, d);
        wr(5'h08, 32'd5 << 9);
        ticks(48);
        chk("R7 low limit waits wrap", {31'h0, irq}, 32'h0);
        rd(5'h04, d); chk("R7 count after wrap", d, 32'd4 << 9);
        ticks(1);
        chk("R7 irq after wrap", {31'h0, irq}, 32'h1);
        rd(5'h04, d); chk("R7 count at low limit", d, 32'h8000_0000 | (32'd5 << 9));
        rd(5'h00, d);

        // R3 free-run wrap
        wr(5'h00, 32'h0);
        ticks(63);
        rd(5'h04, d); chk("R3 at maximum", d, 32'h0000_7E00);
        ticks(1);
        rd(5'h04, d); chk("R3 wrap to zero", d, 32'h0);
        ticks(70);
        rd(5'h04, d); chk("R3 no reached", d, 32'd6 << 9);
        chk("R3 no irq", {31'h0, irq}, 32'h0);

        // R12 entry to user mode with run bit clear
        wr(5'h00, 32'd3 << 9);
        ticks(3);
        chk("R12 irq before entry", {31'h0, irq}, 32'h1);
        set_mode(1'b1);
        chk("R12 irq dropped", {31'h0, irq}, 32'h0);
        rd(5'h04, d); chk("R12 count kept", d, 32'h0000_0600);
        rd(5'h00, d); chk("R12 reached cleared", d, 32'h0);
        rd(5'h0C, d); chk("R10 run bit clear", d, 32'h0);
        ticks(3);
        rd(5'h04, d); chk("R10 halted holds", d, 32'h0000_0600);

        // R9 presets and word layout
        wr(5'h04, 32'hFFFF_FE00);
        wr(5'h00, 32'h0000_0005);
        rd(5'h04, d); chk("R9 low preset", d, 32'hFFFF_FE00);
        rd(5'h00, d); chk("R9 high preset", d, 32'h0000_0005);
        wr(5'h0C, 32'h1);
        rd(5'h0C, d); chk("R10 run bit set", d, 32'h1);
        ticks(1);
        rd(5'h04, d); chk("R9 carry low", d, 32'h0);
        rd(5'h00, d); chk("R9 carry high", d, 32'h0000_0006);
        ticks(3);
        rd(5'h04, d); chk("R10 running", d, 32'h0000_0600);

        // R11 user wrap
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, d); chk("R9 high masked", d, 32'h003F_FFFF);
        wr(5'h04, 32'hFFFF_FE00);
        ticks(1);
        rd(5'h04, d); chk("R11 wrap low", d, 32'h0);
        rd(5'h00, d); chk("R11 wrap sets reached", d, 32'h8000_0000);
        rd(5'h00, d); chk("R11 reached not cleared", d, 32'h8000_0000);
        chk("R11 no irq", {31'h0, irq}, 32'h0);
        for (int k = 0; k < 8; k++) begin
            wr(5'h00, 32'(k));
            wr(5'h04, 32'hFFFF_FE00 - (32'(k) << 9));
            ticks(k + 1);
            rd(5'h00, d); chk("R9 carry sweep high", d, 32'h8000_0000 | 32'(k + 1));
            rd(5'h04, d); chk("R9 carry sweep low", d, 32'h0);
        end

        // R10 stop
        wr(5'h0C, 32'h0);
        rd(5'h0C, d); chk("R10 stopped bit", d, 32'h0);
        rd(5'h04, held);
        ticks(5);
        rd(5'h04, d); chk("R10 stop holds", d, held);

        // R13 return to counter mode
        wr(5'h0C, 32'h1);
        set_mode(1'b0);
        rd(5'h00, d); chk("R13 limit cleared", d, 32'h0);
        rd(5'h04, d); chk("R13 count cleared", d, 32'h0);
        ticks(2);
        rd(5'h04, d); chk("R13 runs free", d, 32'h0000_0400);
        chk("R13 no irq", {31'h0, irq}, 32'h0);

        // R12 entry with run bit set
        set_mode(1'b1);
        rd(5'h0C, d); chk("R12 run bit kept", d, 32'h1);
        ticks(2);
        rd(5'h04, d); chk("R12 runs at once", d, 32'h0000_0800);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule